// File: doc/BRIEF.md
# Multi-channel reloadable down-counter timer

A register-mapped timer with several independent channels, three by default. Each channel holds a 32-bit count that moves downward once per prescaled tick of the functional clock. When a tick finds the count at zero, the channel copies its 32-bit reload value back into the count and raises a sticky underflow flag. The flag drives the channel's interrupt line when the channel's enable bit is set.

One shared byte-wide start register sits below the channel windows and holds one run bit per channel. Software uses a channel in one of two ways. It can load the reload value with a period to get a periodic tick. It can load all-ones to get a maximum-length interval and read elapsed time as the count XOR all-ones. Software clears a pending interrupt by rewriting the control word with the flag bit cleared.

Top module: `mt_top`

## Requirements
- R1: The start register is at byte address 0x00. Channel c occupies 12 bytes from 0x04 + 12*c: reload at +0, count at +4, control at +8. An access whose address is not a multiple of 4, or that falls outside every register, writes nothing and reads 0.
- R2: bus_size selects the lanes: 0 selects bits 7:0, 1 selects bits 15:0, 2 or 3 selects all 32 bits. A write changes only the selected bits. A read returns zero above the selected lanes.
- R3: After reset the start register reads 0, every reload and count register reads 0xFFFFFFFF, every control register reads 0, and all irq outputs are low.
- R4: Start-register bit c runs channel c, and bits at or above the channel count read as 0. Running one channel leaves the count of every other channel unchanged.
- R5: Control bits 2:0 select the tick divisor. Encodings 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024, and 5 to 7 also give 1024. The first tick comes div clock edges after the edge that sets the run bit, and later ticks follow every div edges. The divisor count restarts each time the channel is started.
- R6: On a tick the count decreases by one. A tick that finds the count at 0 loads the reload value instead, so a channel wraps without losing a tick.
- R7: Control bit 8 is a sticky underflow flag. Underflow sets it. It clears only when a control write covering bit 8 writes 0 there, and an underflow in the same cycle as that write wins.
- R8: Control bit 5 is the interrupt enable, and irq[c] is high exactly when channel c has both its flag and its enable set. Writing 0x0020 clears the flag and keeps the enable on. Writing 0x0000 clears both.
- R9: A stopped channel holds its count. The reload and count registers accept writes at any time.
- R10: A channel started from a count of all-ones shows elapsed ticks as the count XOR 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data, aligned to bit 0 |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 or 3 word |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH (3) | Per-channel interrupt request |

## Verification
The bench runs each channel for a known number of clock edges and compares the stopped count against the tick total that the requirements predict. An off-by-one in the divisor or a late prescaler restart therefore shows up as a wrong count on the first read after the run. A count that fails to reload, or a flag that clears by itself, shows up at the next count or control read. A bad flag or enable state shows on irq in the same cycle. Lane masking and channel isolation are checked by reading back neighbouring registers straight after each write or run.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int DATA_W    = 32;
    localparam int CTRL_W    = 16;
    localparam int SEL_W     = 3;
    localparam int PRE_W     = 10;   // holds divisor - 1 for the largest divisor (1024)
    localparam int IE_BIT    = 5;
    localparam int UF_BIT    = 8;
    localparam int WIN_BYTES = 12;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2
    } chreg_e;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale
    import mt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t             st_q, st_d;
    logic [SEL_W-1:0] sel_c;
    logic [PRE_W-1:0] lim;

    always_comb begin
        sel_c = (sel > 3'd4) ? 3'd4 : sel;
        lim   = PRE_W'((32'd4 << {sel_c, 1'b0}) - 32'd1);
        tick  = run && (st_q.cnt >= lim);
        st_d  = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
        logic [SEL_W-1:0]  sel;
        logic              ie;
        logic              uf;
    } ch_t;

    ch_t               st_q, st_d;
    logic              tick;
    logic              uf_evt;
    logic [CTRL_W-1:0] ctrl_cur;
    logic [CTRL_W-1:0] ctrl_new;

    mt_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (st_q.sel),
        .tick  (tick)
    );

    always_comb begin
        ctrl_cur = {7'b0, st_q.uf, 2'b0, st_q.ie, 2'b0, st_q.sel};
        ctrl_new = (ctrl_cur & ~wmask[CTRL_W-1:0]) | (wdata[CTRL_W-1:0] & wmask[CTRL_W-1:0]);
        st_d     = st_q;
        uf_evt   = 1'b0;

        if (tick) begin
            if (st_q.count == '0) begin
                st_d.count = st_q.reload;
                uf_evt     = 1'b1;
            end else begin
                st_d.count = st_q.count - DATA_W'(1);
            end
        end
        if (wr_count) begin
            st_d.count = (st_q.count & ~wmask) | (wdata & wmask);
        end
        if (wr_reload) begin
            st_d.reload = (st_q.reload & ~wmask) | (wdata & wmask);
        end
        if (wr_ctrl) begin
            st_d.sel = ctrl_new[SEL_W-1:0];
            st_d.ie  = ctrl_new[IE_BIT];
            st_d.uf  = st_q.uf & ctrl_new[UF_BIT];
        end
        if (uf_evt) begin
            st_d.uf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{reload: '1, count: '1, sel: '0, ie: 1'b0, uf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign ctrl_o   = ctrl_cur;
    assign irq_o    = st_q.uf & st_q.ie;
endmodule

// File: rtl/mt_top.sv
module mt_top
    import mt_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int START_ADDR = 0;
    localparam int CH_BASE    = 4;

    typedef struct packed {
        logic [NCH-1:0] run;
    } start_t;

    start_t                       start_q, start_d;
    logic [DATA_W-1:0]            wmask;
    logic                         start_hit;
    logic [NCH-1:0]               run_q;
    logic [NCH-1:0]               ch_hit;
    logic [NCH-1:0][1:0]          ch_idx;
    logic [NCH-1:0]               wr_reload, wr_count, wr_ctrl;
    logic [NCH-1:0][DATA_W-1:0]   ch_reload, ch_count;
    logic [NCH-1:0][CTRL_W-1:0]   ch_ctrl;
    logic [DATA_W-1:0]            rd;

    assign wmask     = lane_mask(bus_size);
    assign start_hit = (bus_addr == ADDR_W'(START_ADDR));
    assign run_q     = start_q.run;

    always_comb begin
        start_d = start_q;
        if (bus_we && start_hit) begin
            start_d.run = (start_q.run & ~wmask[NCH-1:0]) | (bus_wdata[NCH-1:0] & wmask[NCH-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else begin
            start_q <= start_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int BASE = CH_BASE + WIN_BYTES * g;

        assign ch_hit[g] = (bus_addr >= ADDR_W'(BASE))
                        && (bus_addr < ADDR_W'(BASE + WIN_BYTES))
                        && (bus_addr[1:0] == 2'b00);
        assign ch_idx[g]    = 2'((bus_addr - ADDR_W'(BASE)) >> 2);
        assign wr_reload[g] = bus_we && ch_hit[g] && (ch_idx[g] == REG_RELOAD);
        assign wr_count[g]  = bus_we && ch_hit[g] && (ch_idx[g] == REG_COUNT);
        assign wr_ctrl[g]   = bus_we && ch_hit[g] && (ch_idx[g] == REG_CTRL);

        mt_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (start_q.run[g]),
            .wr_reload (wr_reload[g]),
            .wr_count  (wr_count[g]),
            .wr_ctrl   (wr_ctrl[g]),
            .wdata     (bus_wdata),
            .wmask     (wmask),
            .reload_o  (ch_reload[g]),
            .count_o   (ch_count[g]),
            .ctrl_o    (ch_ctrl[g]),
            .irq_o     (irq[g])
        );
    end

    always_comb begin
        rd = '0;
        if (start_hit) begin
            rd = DATA_W'(start_q.run);
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_hit[c]) begin
                case (ch_idx[c])
                    REG_RELOAD: rd = ch_reload[c];
                    REG_COUNT:  rd = ch_count[c];
                    REG_CTRL:   rd = DATA_W'(ch_ctrl[c]);
                    default:    rd = '0;
                endcase
            end
        end
        bus_rdata = rd & wmask;
    end
endmodule

// File: rtl/mt_top_chk.sv
module mt_top_chk
    import mt_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0]           run_q,
    input logic [NCH-1:0]           wr_count,
    input logic [NCH-1:0]           wr_ctrl,
    input logic [NCH-1:0][DATA_W-1:0] ch_count,
    input logic [NCH-1:0][DATA_W-1:0] ch_reload,
    input logic [NCH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NCH-1:0]           irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R9: a stopped channel whose count is not written keeps its count
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[g] && !wr_count[g]) |=> $stable(ch_count[g]));

        // R6: a running channel holds, steps down by one, or wraps to reload from zero
        p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[g] && !wr_count[g]) |=>
                (ch_count[g] == $past(ch_count[g]))
             || (ch_count[g] == $past(ch_count[g]) - DATA_W'(1))
             || (($past(ch_count[g]) == '0) && (ch_count[g] == $past(ch_reload[g]))));

        // R6: the flag only rises out of a zero count
        p_uf_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ctrl[g][UF_BIT]) |-> ($past(ch_count[g]) == '0));

        // R7: without a control write the flag cannot clear
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[g][UF_BIT] && !wr_ctrl[g]) |=> ch_ctrl[g][UF_BIT]);

        // R8: an interrupt needs both the enable and the flag
        p_irq_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (ch_ctrl[g][IE_BIT] && ch_ctrl[g][UF_BIT]));
    end
endmodule

bind mt_top mt_top_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .wr_count  (wr_count),
    .wr_ctrl   (wr_ctrl),
    .ch_count  (ch_count),
    .ch_reload (ch_reload),
    .ch_ctrl   (ch_ctrl),
    .irq       (irq)
);

// File: tb/mt_top_test.sv
module mt_top_test;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mt_top #(.NCH(NCH), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] ra(input int c, input int idx);
        return 8'(4 + 12 * c + 4 * idx);
    endfunction

    function automatic int divisor(input int sel);
        return (sel >= 4) ? 1024 : (4 << (2 * sel));
    endfunction

    // count after a number of ticks, per the reload/decrement rule
    function automatic logic [32:0] model(input logic [31:0] cnt, input logic [31:0] rld, input int ticks);
        logic uf = 1'b0;
        for (int i = 0; i < ticks; i++) begin
            if (cnt == 0) begin cnt = rld; uf = 1'b1; end
            else cnt = cnt - 1;
        end
        return {uf, cnt};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_we = 1'b0;
        #2;
        d = bus_rdata;
    endtask

    // run bit set at edge E0, cleared at edge E_m; ticks = m / div
    task automatic run_for(input int c, input int m);
        wr(8'h00, 32'(1 << c), 2'd0);
        repeat (m - 2) @(negedge clk);
        wr(8'h00, 32'h0, 2'd0);
    endtask

    initial begin
        repeat (1900000 / 10) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [32:0] e;
        int seed;
        seed = $urandom(32'd4711);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        rd(8'h00, 2'd2, v); chk("R3 start", v, 32'h0);
        rd(ra(0, 0), 2'd2, v); chk("R3 reload0", v, 32'hFFFF_FFFF);
        rd(ra(1, 1), 2'd2, v); chk("R3 count1", v, 32'hFFFF_FFFF);
        rd(ra(2, 2), 2'd2, v); chk("R3 ctrl2", v, 32'h0);
        chk("R3 irq", 32'(irq), 32'h0);

        // R4 unused start bits read as zero and start nothing
        wr(8'h00, 32'hF8, 2'd0);
        rd(8'h00, 2'd2, v); chk("R4 start upper bits", v, 32'h0);

        // R1 unaligned write ignored, unaligned read gives zero
        wr(8'h05, 32'h0, 2'd2);
        rd(ra(0, 0), 2'd2, v); chk("R1 unaligned write", v, 32'hFFFF_FFFF);
        rd(8'h06, 2'd2, v); chk("R1 unaligned read", v, 32'h0);

        // R2 lane masking
        wr(ra(0, 1), 32'h1234_5678, 2'd2);
        wr(ra(0, 1), 32'hFFFF_FFAB, 2'd0);
        rd(ra(0, 1), 2'd2, v); chk("R2 byte write", v, 32'h1234_56AB);
        rd(ra(0, 1), 2'd1, v); chk("R2 half read", v, 32'h0000_56AB);

        // R5 divide by 1024: one edge short of the second tick
        wr(ra(2, 2), 32'h4, 2'd1);
        wr(ra(2, 0), 32'd5, 2'd2);
        wr(ra(2, 1), 32'd1, 2'd2);
        run_for(2, 2047);
        rd(ra(2, 1), 2'd2, v); chk("R5 div1024 one tick", v, 32'd0);
        rd(ra(2, 2), 2'd2, v); chk("R5 no flag yet", v, 32'h0004);
        wr(ra(2, 1), 32'd1, 2'd2);
        run_for(2, 2048);
        rd(ra(2, 1), 2'd2, v); chk("R6 reload after zero", v, 32'd5);
        rd(ra(2, 2), 2'd2, v); chk("R7 flag set", v, 32'h0104);
        rd(ra(0, 1), 2'd2, v); chk("R4 other channel untouched", v, 32'h1234_56AB);

        // R7/R8 flag, enable and acknowledge
        chk("R8 irq off without enable", 32'(irq[2]), 32'h0);
        wr(ra(2, 2), 32'h0124, 2'd1);
        chk("R8 irq on", 32'(irq[2]), 32'h1);
        wr(ra(2, 2), 32'h0004, 2'd0);
        rd(ra(2, 2), 2'd2, v); chk("R7 byte write keeps flag", v, 32'h0104);
        chk("R8 irq off after disable", 32'(irq[2]), 32'h0);
        wr(ra(2, 2), 32'h0120, 2'd1);
        chk("R8 irq back on", 32'(irq[2]), 32'h1);
        wr(ra(2, 2), 32'h0020, 2'd1);
        rd(ra(2, 2), 2'd2, v); chk("R8 ack keeps enable", v, 32'h0020);
        chk("R8 irq acked", 32'(irq[2]), 32'h0);

        // R10 elapsed time from all-ones
        wr(ra(1, 2), 32'h0, 2'd1);
        wr(ra(1, 0), 32'hFFFF_FFFF, 2'd2);
        wr(ra(1, 1), 32'hFFFF_FFFF, 2'd2);
        run_for(1, 403);
        rd(ra(1, 1), 2'd2, v); chk("R10 elapsed", v ^ 32'hFFFF_FFFF, 32'd100);

        // R9 stopped channel holds
        repeat (50) @(negedge clk);
        rd(ra(1, 1), 2'd2, v); chk("R9 hold", v ^ 32'hFFFF_FFFF, 32'd100);

        // R6 wrap from zero to all-ones
        wr(ra(1, 1), 32'h0, 2'd2);
        run_for(1, 4);
        rd(ra(1, 1), 2'd2, v); chk("R6 wrap", v, 32'hFFFF_FFFF);
        rd(ra(1, 2), 2'd2, v); chk("R7 wrap flag", v, 32'h0100);

        // constrained random runs (R5 R6 R7 R8)
        for (int it = 0; it < 24; it++) begin
            int c, sel, ie, m;
            logic [31:0] rl, c0;
            c   = int'($urandom % NCH);
            sel = int'($urandom % 4);
            ie  = int'($urandom % 2);
            rl  = $urandom % 6;
            c0  = (it % 5 == 4) ? $urandom : ($urandom % 6);
            m   = 2 + int'($urandom % (divisor(sel) * 8));
            wr(ra(c, 2), 32'(sel | (ie << 5)), 2'd1);
            wr(ra(c, 0), rl, 2'd2);
            wr(ra(c, 1), c0, 2'd2);
            run_for(c, m);
            e = model(c0, rl, m / divisor(sel));
            rd(ra(c, 1), 2'd2, v); chk("R5 R6 random count", v, e[31:0]);
            rd(ra(c, 2), 2'd2, v); chk("R7 random ctrl", v, 32'(sel | (ie << 5) | (int'(e[32]) << 8)));
            chk("R8 random irq", 32'(irq[c]), 32'(e[32] & ie[0]));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule